// File: doc/BRIEF.md
# Segment-List Configuration Save/Restore Sequencer

This block moves configuration bytes between a sparse register bank and a byte-wide nonvolatile store. The registers it moves are chosen by a short list of descriptors that it holds in a small private buffer. Each list entry is one of three things. The first is a run, which gives a byte count and a 16-bit starting register address. The second is an update opcode, which pulses a request to copy the buffer registers into the active registers. The third is a terminator. Because the list can hold several runs, gaps in the register map are skipped without any cost.

A one-cycle start pulse launches a walk in one of two directions. A save reads the registers and writes them one after another into the store from byte 0, and then adds a checksum byte. A restore reads the same bytes back, writes them to the registers and recomputes the checksum. The block reports a busy flag, which can also be routed to a pin, and a sticky error flag. The store is an internal synchronous byte array with a one-cycle read.

Top module: `ee_seg_sequencer`

## Requirements
- R1: After reset, busy, err, status_pin and upd_pulse are 0, and the list holds its default contents (see R7).
- R2: A start pulse while idle makes busy 1 and err 0 on the next cycle. A start pulse while busy is ignored, so the walk in progress runs to its normal end.
- R3: A list byte from 1 to 127 (bit 7 clear) is a run count. It is followed by the address high byte and then the address low byte. A save copies that many consecutive registers into consecutive store bytes, starting at store byte 0 for the first run. A restore writes those store bytes back to the same registers.
- R4: A save writes one extra store byte after the data: the 8-bit two's-complement negation of the sum of the data bytes. A restore sets err to 1 if the stored byte differs from the negated sum it recomputes. err stays set until the next accepted start.
- R5: List byte 0x80 raises upd_pulse for exactly one cycle each time the walk reaches it, in both directions.
- R6: List byte 0xFF ends the walk. If the walk reaches the end of the 23-entry list without seeing 0xFF, it finishes as if 0xFF had been seen.
- R7: The default list saves 16 registers from 0x0000 and 8 registers from 0x0100, then issues one update, then ends.
- R8: status_pin equals busy while route_en is 1, and stays 0 while route_en is 0.
- R9: Busy lasts 3 cycles per run header plus 1 cycle per other list byte read. On top of that, a save adds 1 cycle per data byte and 1 final cycle, and a restore adds 2 cycles per data byte and 2 final cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a walk |
| dir_restore | input | 1 | 0 for save, 1 for restore; sampled at start |
| route_en | input | 1 | Routes busy to status_pin |
| list_we | input | 1 | Writes one list byte; ignored while busy |
| list_idx | input | 5 | List entry index for the write (0 to 22) |
| list_wdata | input | 8 | List byte to write |
| bank_addr | output | 16 | Register address being accessed |
| bank_rdata | input | 8 | Register read data, valid in the same cycle |
| bank_we | output | 1 | Register write strobe (restore) |
| bank_wdata | output | 8 | Register write data |
| upd_pulse | output | 1 | Request to copy buffer registers into active registers |
| busy | output | 1 | Walk in progress |
| err | output | 1 | Sticky checksum mismatch flag |
| status_pin | output | 1 | busy, gated by route_en |

## Verification
busy and err change on the first clock edge after a start pulse is accepted, so the bench samples them at the following falling edge. The bench counts falling edges while busy is high and compares that count with the cycle total that R9 gives for each list. The final value of err is read once busy has dropped, because the checksum compare and the exit to idle happen on the same edge. Restored register data is checked in the bench's register model after the walk ends, and update pulses are counted for the whole walk.

// File: rtl/ee_seq_pkg.sv
package ee_seq_pkg;
    localparam int LIST_LEN = 23;
    localparam int LIDX_W   = 5;
    localparam logic [7:0] OP_UPDATE = 8'h80;
    localparam logic [7:0] OP_END    = 8'hFF;

    typedef enum logic [2:0] {
        S_IDLE, S_FCNT, S_FHI, S_FLO, S_MOVE, S_LAND, S_CK, S_CKCHK
    } seq_state_e;

    function automatic logic [7:0] default_list_byte(input int i);
        case (i)
            0: return 8'd16;
            1: return 8'h00;
            2: return 8'h00;
            3: return 8'd8;
            4: return 8'h01;
            5: return 8'h00;
            6: return OP_UPDATE;
            default: return OP_END;
        endcase
    endfunction
endpackage

// File: rtl/ee_list_buf.sv
module ee_list_buf
    import ee_seq_pkg::*;
#(
    parameter int LEN = LIST_LEN,
    parameter int IW  = LIDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [7:0]    wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [7:0]    rd_data
);
    logic [7:0] list_d [LEN];
    logic [7:0] list_q [LEN];

    always_comb begin
        for (int i = 0; i < LEN; i++) list_d[i] = list_q[i];
        if (wr_en && (int'(wr_idx) < LEN)) list_d[wr_idx] = wr_data;
        rd_data = (int'(rd_idx) < LEN) ? list_q[rd_idx] : OP_END;
    end

    generate
        for (genvar g = 0; g < LEN; g++) begin : g_ent
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) list_q[g] <= default_list_byte(g);
                else        list_q[g] <= list_d[g];
            end
        end
    endgenerate
endmodule

// File: rtl/ee_store.sv
module ee_store #(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem_d [DEPTH];
    logic [7:0] mem_q [DEPTH];
    logic [7:0] rdata_d, rdata_q;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
        if (we) mem_d[waddr] = wdata;
        rdata_d = mem_q[raddr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
            rdata_q <= 8'hFF;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
            rdata_q <= rdata_d;
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/ee_seq_ctrl.sv
module ee_seq_ctrl
    import ee_seq_pkg::*;
#(
    parameter int LEN = LIST_LEN,
    parameter int IW  = LIDX_W,
    parameter int AW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          dir_restore,
    output logic [IW-1:0] list_rd_idx,
    input  logic [7:0]    list_byte,
    output logic [15:0]   bank_addr,
    input  logic [7:0]    bank_rdata,
    output logic          bank_we,
    output logic [7:0]    bank_wdata,
    output logic          st_we,
    output logic [AW-1:0] st_waddr,
    output logic [7:0]    st_wdata,
    output logic [AW-1:0] st_raddr,
    input  logic [7:0]    st_rdata,
    output logic          upd_pulse,
    output logic          busy,
    output logic          err
);
    typedef struct packed {
        seq_state_e    st;
        logic          dir;
        logic [IW-1:0] idx;
        logic [6:0]    cnt;
        logic [15:0]   addr;
        logic [AW-1:0] sp;
        logic [7:0]    sum;
        logic          busy;
        logic          err;
    } ctrl_t;

    ctrl_t c_d, c_q;
    logic list_done;

    assign list_done = (int'(c_q.idx) >= LEN);

    always_comb begin
        c_d         = c_q;
        list_rd_idx = c_q.idx;
        bank_addr   = c_q.addr;
        bank_we     = 1'b0;
        bank_wdata  = st_rdata;
        st_we       = 1'b0;
        st_waddr    = c_q.sp;
        st_wdata    = bank_rdata;
        st_raddr    = c_q.sp;
        upd_pulse   = 1'b0;

        unique case (c_q.st)
            S_IDLE: begin
                if (start) begin
                    c_d.st   = S_FCNT;
                    c_d.dir  = dir_restore;
                    c_d.idx  = '0;
                    c_d.sp   = '0;
                    c_d.sum  = '0;
                    c_d.busy = 1'b1;
                    c_d.err  = 1'b0;
                end
            end
            S_FCNT: begin
                if (list_done || list_byte == OP_END) begin
                    c_d.st = S_CK;
                end else if (list_byte == OP_UPDATE) begin
                    upd_pulse = 1'b1;
                    c_d.idx   = c_q.idx + 1'b1;
                end else if (list_byte[7] || list_byte == 8'h00) begin
                    c_d.idx = c_q.idx + 1'b1;
                end else begin
                    c_d.cnt = list_byte[6:0];
                    c_d.idx = c_q.idx + 1'b1;
                    c_d.st  = S_FHI;
                end
            end
            S_FHI: begin
                if (list_done) begin
                    c_d.st = S_CK;
                end else begin
                    c_d.addr[15:8] = list_byte;
                    c_d.idx        = c_q.idx + 1'b1;
                    c_d.st         = S_FLO;
                end
            end
            S_FLO: begin
                if (list_done) begin
                    c_d.st = S_CK;
                end else begin
                    c_d.addr[7:0] = list_byte;
                    c_d.idx       = c_q.idx + 1'b1;
                    c_d.st        = S_MOVE;
                end
            end
            S_MOVE: begin
                if (!c_q.dir) begin
                    st_we    = 1'b1;
                    c_d.sum  = c_q.sum + bank_rdata;
                    c_d.sp   = c_q.sp + 1'b1;
                    c_d.addr = c_q.addr + 16'd1;
                    c_d.cnt  = c_q.cnt - 7'd1;
                    if (c_q.cnt == 7'd1) c_d.st = S_FCNT;
                end else begin
                    c_d.st = S_LAND;
                end
            end
            S_LAND: begin
                bank_we  = 1'b1;
                c_d.sum  = c_q.sum + st_rdata;
                c_d.sp   = c_q.sp + 1'b1;
                c_d.addr = c_q.addr + 16'd1;
                c_d.cnt  = c_q.cnt - 7'd1;
                c_d.st   = (c_q.cnt == 7'd1) ? S_FCNT : S_MOVE;
            end
            S_CK: begin
                if (!c_q.dir) begin
                    st_we    = 1'b1;
                    st_wdata = 8'd0 - c_q.sum;
                    c_d.st   = S_IDLE;
                    c_d.busy = 1'b0;
                end else begin
                    c_d.st = S_CKCHK;
                end
            end
            S_CKCHK: begin
                c_d.err  = (st_rdata != (8'd0 - c_q.sum));
                c_d.st   = S_IDLE;
                c_d.busy = 1'b0;
            end
            default: c_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{st: S_IDLE, dir: 1'b0, idx: '0, cnt: '0, addr: '0,
                     sp: '0, sum: '0, busy: 1'b0, err: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    assign busy = c_q.busy;
    assign err  = c_q.err;

    AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !err)); // R2
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy && c_q.st != S_CK && c_q.st != S_CKCHK) |=> busy); // R2
    AST_ERR_AT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $fell(busy)); // R4
    AST_UPD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pulse |-> busy); // R5
    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(c_q.idx) <= LEN); // R6
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!bank_we && !st_we && !upd_pulse)); // R3
endmodule

// File: rtl/ee_seg_sequencer.sv
module ee_seg_sequencer
    import ee_seq_pkg::*;
#(
    parameter int STORE_DEPTH = 256,
    parameter int SAW         = $clog2(STORE_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dir_restore,
    input  logic              route_en,
    input  logic              list_we,
    input  logic [LIDX_W-1:0] list_idx,
    input  logic [7:0]        list_wdata,
    output logic [15:0]       bank_addr,
    input  logic [7:0]        bank_rdata,
    output logic              bank_we,
    output logic [7:0]        bank_wdata,
    output logic              upd_pulse,
    output logic              busy,
    output logic              err,
    output logic              status_pin
);
    logic [LIDX_W-1:0] rd_idx;
    logic [7:0]        list_byte;
    logic              st_we;
    logic [SAW-1:0]    st_waddr, st_raddr;
    logic [7:0]        st_wdata, st_rdata;

    ee_list_buf #(.LEN(LIST_LEN), .IW(LIDX_W)) u_list (
        .clk(clk), .rst_n(rst_n),
        .wr_en(list_we && !busy), .wr_idx(list_idx), .wr_data(list_wdata),
        .rd_idx(rd_idx), .rd_data(list_byte)
    );

    ee_store #(.DEPTH(STORE_DEPTH), .AW(SAW)) u_store (
        .clk(clk), .rst_n(rst_n),
        .we(st_we), .waddr(st_waddr), .wdata(st_wdata),
        .raddr(st_raddr), .rdata(st_rdata)
    );

    ee_seq_ctrl #(.LEN(LIST_LEN), .IW(LIDX_W), .AW(SAW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .start(start), .dir_restore(dir_restore),
        .list_rd_idx(rd_idx), .list_byte(list_byte),
        .bank_addr(bank_addr), .bank_rdata(bank_rdata),
        .bank_we(bank_we), .bank_wdata(bank_wdata),
        .st_we(st_we), .st_waddr(st_waddr), .st_wdata(st_wdata),
        .st_raddr(st_raddr), .st_rdata(st_rdata),
        .upd_pulse(upd_pulse), .busy(busy), .err(err)
    );

    assign status_pin = busy & route_en;

    AST_PIN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !route_en |-> !status_pin); // R8
endmodule

// File: tb/tb_ee_seg_sequencer.sv
module tb_ee_seg_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, dir_restore = 1'b0, route_en = 1'b1;
    logic        list_we = 1'b0;
    logic [4:0]  list_idx = '0;
    logic [7:0]  list_wdata = '0;
    logic [15:0] bank_addr;
    logic [7:0]  bank_rdata, bank_wdata;
    logic        bank_we, upd_pulse, busy, err, status_pin;

    logic [7:0] bmem [1024];
    int total = 0, bad = 0, upd_cnt = 0, wd = 0;

    always #4 clk = ~clk;

    ee_seg_sequencer dut (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_restore(dir_restore),
        .route_en(route_en), .list_we(list_we), .list_idx(list_idx),
        .list_wdata(list_wdata), .bank_addr(bank_addr), .bank_rdata(bank_rdata),
        .bank_we(bank_we), .bank_wdata(bank_wdata), .upd_pulse(upd_pulse),
        .busy(busy), .err(err), .status_pin(status_pin)
    );

    assign bank_rdata = bmem[bank_addr[9:0]];
    always @(posedge clk) begin
        if (bank_we) bmem[bank_addr[9:0]] <= bank_wdata;
        if (upd_pulse) upd_cnt <= upd_cnt + 1;
    end

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 11) ^ (a >> 3));
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic seed(input int a0, input int n);
        for (int i = 0; i < n; i++) bmem[a0 + i] = pat(a0 + i);
    endtask
    task automatic wipe(input int a0, input int n);
        for (int i = 0; i < n; i++) bmem[a0 + i] = 8'h00;
    endtask
    task automatic verify(input int a0, input int n, input string req);
        int miss = 0;
        for (int i = 0; i < n; i++) if (bmem[a0 + i] !== pat(a0 + i)) miss++;
        chk(miss == 0, req, miss, 0);
    endtask

    task automatic put(input int idx, input logic [7:0] v);
        @(negedge clk);
        list_we = 1'b1; list_idx = 5'(idx); list_wdata = v;
        @(negedge clk);
        list_we = 1'b0;
    endtask

    task automatic one_run(input int n, input int a);
        put(0, 8'(n)); put(1, 8'(a >> 8)); put(2, 8'(a)); put(3, 8'hFF);
    endtask

    task automatic run(input logic rd, input logic mid, output int cyc);
        @(negedge clk);
        upd_cnt = 0;
        dir_restore = rd; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && !err, "R2 start accepted", {30'd0, busy, err}, 2);
        if (route_en) chk(status_pin == 1'b1, "R8 pin follows busy", status_pin, 1);
        else          chk(status_pin == 1'b0, "R8 pin gated", status_pin, 0);
        cyc = 0;
        while (busy && cyc < 5000) begin
            cyc++;
            if (mid && cyc == 3) begin start = 1'b1; dir_restore = ~rd; end
            else start = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    localparam logic [23:0] VEC [4] = '{
        {8'd1,   16'h0002},
        {8'd5,   16'h0030},
        {8'd3,   16'h03FD},
        {8'd127, 16'h0200}
    };

    initial begin
        forever begin
            @(posedge clk);
            wd++;
            if (wd > 150000) begin
                bad++; total++;
                $display("FAIL watchdog actual=%0d expected=0", wd);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        int cyc;
        for (int i = 0; i < 1024; i++) bmem[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy && !err && !status_pin && !upd_pulse, "R1 reset outputs",
            {28'd0, busy, err, status_pin, upd_pulse}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R7 default list, R9 timing, R5 single update
        seed(0, 16); seed(16'h100, 8);
        run(1'b0, 1'b0, cyc);
        chk(cyc == 33, "R9 default save cycles", cyc, 33);
        chk(upd_cnt == 1, "R5 one update on save", upd_cnt, 1);
        wipe(0, 16); wipe(16'h100, 8);
        run(1'b1, 1'b0, cyc);
        chk(cyc == 58, "R9 default restore cycles", cyc, 58);
        chk(upd_cnt == 1, "R5 one update on restore", upd_cnt, 1);
        verify(0, 16, "R7 default run 0x0000");
        verify(16'h100, 8, "R7 default run 0x0100");
        chk(err == 1'b0, "R4 no error on good data", err, 0);

        // R3 table of single runs
        for (int v = 0; v < 4; v++) begin
            int n = int'(VEC[v][23:16]);
            int a = int'(VEC[v][15:0]);
            one_run(n, a);
            seed(a, n);
            run(1'b0, 1'b0, cyc);
            chk(cyc == n + 5, "R9 run save cycles", cyc, n + 5);
            wipe(a, n);
            run(1'b1, 1'b0, cyc);
            chk(cyc == 2 * n + 6, "R9 run restore cycles", cyc, 2 * n + 6);
            verify(a, n, "R3 run restored");
            chk(err == 1'b0, "R4 checksum ok", err, 0);
        end

        // R4 mismatch: restore one byte more than saved
        one_run(2, 16'h0080);
        seed(16'h80, 3);
        run(1'b0, 1'b0, cyc);
        put(0, 8'd3);
        run(1'b1, 1'b0, cyc);
        chk(err == 1'b1, "R4 mismatch sets err", err, 1);
        repeat (4) @(negedge clk);
        chk(err == 1'b1, "R4 err sticky", err, 1);
        put(0, 8'd2);
        run(1'b1, 1'b0, cyc);
        chk(err == 1'b0, "R4 err cleared by start", err, 0);

        // R2 start while busy ignored
        one_run(5, 16'h0300);
        seed(16'h300, 5);
        run(1'b0, 1'b1, cyc);
        chk(cyc == 10, "R2 busy start ignored", cyc, 10);
        @(negedge clk);
        chk(busy == 1'b0, "R2 no restart", busy, 0);
        wipe(16'h300, 5);
        run(1'b1, 1'b0, cyc);
        verify(16'h300, 5, "R2 save intact after ignored start");

        // R6 implicit end: seven one-byte runs then two updates, no terminator
        for (int k = 0; k < 7; k++) begin
            put(3 * k, 8'd1); put(3 * k + 1, 8'h01); put(3 * k + 2, 8'(8'h40 + 2 * k));
            bmem[16'h140 + 2 * k] = pat(16'h140 + 2 * k);
        end
        put(21, 8'h80); put(22, 8'h80);
        run(1'b0, 1'b0, cyc);
        chk(cyc == 32, "R6 implicit end save cycles", cyc, 32);
        chk(upd_cnt == 2, "R5 two updates", upd_cnt, 2);
        for (int k = 0; k < 7; k++) bmem[16'h140 + 2 * k] = 8'h00;
        route_en = 1'b0;
        run(1'b1, 1'b0, cyc);
        chk(cyc == 40, "R6 implicit end restore cycles", cyc, 40);
        chk(err == 1'b0, "R6 checksum after implicit end", err, 0);
        begin
            int miss = 0;
            for (int k = 0; k < 7; k++)
                if (bmem[16'h140 + 2 * k] !== pat(16'h140 + 2 * k)) miss++;
            chk(miss == 0, "R6 sparse data restored", miss, 0);
        end
        route_en = 1'b1;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule